// File: doc/BRIEF.md
# Interrupting Memory-Mapped Serial Port

This block is a byte-wide receive and transmit device for a processor's load/store bus. Each direction has a control word and a data word. The control word carries a read-only ready flag and a read/write interrupt-enable flag. Incoming bytes come in on a valid/ready stream and are held one at a time. Outgoing bytes leave on a second valid/ready stream.

Each direction drives its own interrupt line. A line is high on every cycle while that direction is ready and its interrupt is enabled. Software services the line by touching the data word, or silences it by clearing the enable flag.

After every completed data access, the direction enforces a pause before it is ready again. The length of the pause comes from a free-running linear feedback shift register. The pause is never shorter than 4 cycles and never longer than 31 cycles. This lets a processor and its interrupt handler be exercised with irregular device timing.

Top module: `mmsp_serial_port`

## Requirements
- R1: After reset the receive word reads ready=0 and enable=0, and the transmit word reads ready=1 and enable=0. Both interrupt lines are low, `rx_in_ready` is high and `tx_out_valid` is low.
- R2: The register offsets are:
  - 0x0: receive control.
  - 0x4: receive data, with the byte in bits 7:0.
  - 0x8: transmit control.
  - 0xC: transmit data, which reads as zero.

  In a control word, bit 0 is ready and bit 1 is interrupt enable. A store to a control word loads the enable from bit 1 of the write data. All other read bits are zero.
- R3: `irq_rx` equals receive ready AND receive enable, and `irq_tx` equals transmit ready AND transmit enable. Each line stays high on every cycle until its data word is accessed or its enable is cleared.
- R4: A stream byte is accepted only while the receiver holds no byte and its pause has expired. After acceptance, ready is high from the next cycle, the byte is held unchanged, and `rx_in_ready` stays low until the byte is loaded.
- R5: A load from receive data while ready clears ready on the next cycle. It also keeps `rx_in_ready` low for a pause of 4 to 31 cycles.
- R6: A load from receive data while ready is low returns the last byte received and changes no state.
- R7: A store to transmit data while ready places bits 7:0 on `tx_out_data` and clears transmit ready. It also holds `tx_out_valid` with stable data until `tx_out_ready` is seen high.
- R8: Transmit ready returns only once two conditions hold: the output byte has been accepted, and a pause of 4 to 31 cycles after the store has expired.
- R9: A store to transmit data while transmit ready is low is ignored, and the byte on the output is unchanged.
- R10: A store that clears an enable bit drops that direction's interrupt line on the next cycle while the ready flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 4 | Byte offset of the accessed word |
| bus_wdata | input | BUS_W (32) | Store data |
| bus_rdata | output | BUS_W (32) | Load data, valid in the cycle of the access |
| rx_in_valid | input | 1 | Incoming byte valid |
| rx_in_data | input | BYTE_W (8) | Incoming byte |
| rx_in_ready | output | 1 | Receiver can take a byte |
| tx_out_valid | output | 1 | Outgoing byte valid |
| tx_out_data | output | BYTE_W (8) | Outgoing byte |
| tx_out_ready | input | 1 | Sink takes the outgoing byte |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |

## Verification
The directed patterns each separate one fault:
- A byte that is offered while the receiver is already full must not overwrite the held byte.
- A load while the receiver is not ready must return the old byte.
- A transmit store made while the sink is stalled must be dropped.
- A sink that is held off past the pause must keep transmit ready low. This separates gating on acceptance from gating on the timer alone.

The seeded random runs send long byte streams in both directions, with random source gaps and random sink stalls. They show that ordering and data survive irregular handshakes. Every measured pause must fall in 4..31 cycles, and the pauses must take more than one value, which shows that they are not a fixed delay.

// File: rtl/mmsp_pkg.sv
package mmsp_pkg;
   localparam int REG_ADDR_W  = 4;
   localparam int CTL_RDY_BIT = 0;
   localparam int CTL_IEN_BIT = 1;

   typedef enum logic [1:0] {
      SEL_RX_CTL = 2'd0,
      SEL_RX_DAT = 2'd1,
      SEL_TX_CTL = 2'd2,
      SEL_TX_DAT = 2'd3
   } mmsp_reg_e;

   typedef struct packed {
      logic ctl_wr;
      logic ien_val;
      logic dat_acc;
   } mmsp_acc_t;
endpackage

// File: rtl/mmsp_lfsr.sv
module mmsp_lfsr #(
   parameter int              W    = 5,
   parameter logic [W-1:0]    SEED = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] rnd
);
   logic [W-1:0] state;
   logic         fb;

   generate
      if (W == 4) begin : g_w4
         assign fb = state[3] ^ state[2];
      end else if (W == 5) begin : g_w5
         assign fb = state[4] ^ state[2];
      end else if (W == 6) begin : g_w6
         assign fb = state[5] ^ state[4];
      end else if (W == 7) begin : g_w7
         assign fb = state[6] ^ state[5];
      end else if (W == 8) begin : g_w8
         assign fb = state[7] ^ state[5] ^ state[4] ^ state[3];
      end else begin : g_bad
         $error("mmsp_lfsr: width must be 4..8");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("mmsp_lfsr: seed must be nonzero");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) state <= SEED;
      else        state <= {state[W-2:0], fb};
   end

   assign rnd = state;

   a_r5_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (state != '0));
endmodule

// File: rtl/mmsp_gap.sv
module mmsp_gap #(
   parameter int W   = 5,
   parameter int MIN = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] rnd,
   output logic         idle
);
   localparam logic [W-1:0] MIN_V = W'(MIN);

   generate
      if (MIN < 1 || MIN >= (1 << W)) begin : g_bad_min
         $error("mmsp_gap: MIN must lie within the counter range");
      end
   endgenerate

   logic [W-1:0] cnt;
   logic [W-1:0] load_v;

   assign load_v = (rnd < MIN_V) ? MIN_V : rnd;

   always_ff @(posedge clk) begin
      if (!rst_n)           cnt <= '0;
      else if (start)       cnt <= load_v;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign idle = (cnt == '0);

   a_r8_gap_floor: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (cnt >= MIN_V) && !idle);
   a_r5_gap_count: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !idle) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/mmsp_rx_chan.sv
module mmsp_rx_chan #(
   parameter int BYTE_W  = 8,
   parameter int LFSR_W  = 5,
   parameter int GAP_MIN = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  mmsp_pkg::mmsp_acc_t  acc,
   input  logic [LFSR_W-1:0]    rnd,
   input  logic                 in_valid,
   input  logic [BYTE_W-1:0]    in_data,
   output logic                 in_ready,
   output logic                 rdy,
   output logic                 ien,
   output logic [BYTE_W-1:0]    byte_q,
   output logic                 irq
);
   logic take;
   logic accept;
   logic gap_idle;

   assign take     = acc.dat_acc && rdy;
   assign in_ready = !rdy && gap_idle;
   assign accept   = in_valid && in_ready;

   mmsp_gap #(.W(LFSR_W), .MIN(GAP_MIN)) u_gap (
      .clk   (clk),
      .rst_n (rst_n),
      .start (take),
      .rnd   (rnd),
      .idle  (gap_idle)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdy    <= 1'b0;
         ien    <= 1'b0;
         byte_q <= '0;
      end else begin
         if (accept)    rdy <= 1'b1;
         else if (take) rdy <= 1'b0;
         if (accept)     byte_q <= in_data;
         if (acc.ctl_wr) ien    <= acc.ien_val;
      end
   end

   assign irq = rdy & ien;

   a_r4_latch: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> rdy && (byte_q == $past(in_data)));
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy && !acc.dat_acc) |=> rdy && $stable(byte_q));
   a_r5_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !rdy && !in_ready);
   a_r6_idle_load: assert property (@(posedge clk) disable iff (!rst_n)
      (acc.dat_acc && !rdy && !accept) |=> !rdy && $stable(byte_q));
endmodule

// File: rtl/mmsp_tx_chan.sv
module mmsp_tx_chan #(
   parameter int BYTE_W  = 8,
   parameter int LFSR_W  = 5,
   parameter int GAP_MIN = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  mmsp_pkg::mmsp_acc_t  acc,
   input  logic [BYTE_W-1:0]    wbyte,
   input  logic [LFSR_W-1:0]    rnd,
   output logic                 out_valid,
   output logic [BYTE_W-1:0]    out_data,
   input  logic                 out_ready,
   output logic                 rdy,
   output logic                 ien,
   output logic                 irq
);
   logic busy;
   logic put;
   logic gap_idle;

   assign rdy = !busy && gap_idle;
   assign put = acc.dat_acc && rdy;

   mmsp_gap #(.W(LFSR_W), .MIN(GAP_MIN)) u_gap (
      .clk   (clk),
      .rst_n (rst_n),
      .start (put),
      .rnd   (rnd),
      .idle  (gap_idle)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         ien      <= 1'b0;
         out_data <= '0;
      end else begin
         if (put) begin
            busy     <= 1'b1;
            out_data <= wbyte;
         end else if (busy && out_ready) begin
            busy <= 1'b0;
         end
         if (acc.ctl_wr) ien <= acc.ien_val;
      end
   end

   assign out_valid = busy;
   assign irq       = rdy & ien;

   a_r7_put_clears: assert property (@(posedge clk) disable iff (!rst_n)
      put |=> out_valid && !rdy && (out_data == $past(wbyte)));
   a_r7_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> out_valid && $stable(out_data));
   a_r9_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (acc.dat_acc && !rdy) |=> $stable(out_data));
   a_r8_wait_sink: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !rdy);
endmodule

// File: rtl/mmsp_serial_port.sv
module mmsp_serial_port #(
   parameter int                 BUS_W     = 32,
   parameter int                 BYTE_W    = 8,
   parameter int                 LFSR_W    = 5,
   parameter int                 GAP_MIN   = 4,
   parameter logic [LFSR_W-1:0]  LFSR_SEED = 1
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 bus_sel,
   input  logic                                 bus_we,
   input  logic [mmsp_pkg::REG_ADDR_W-1:0]      bus_addr,
   input  logic [BUS_W-1:0]                     bus_wdata,
   output logic [BUS_W-1:0]                     bus_rdata,
   input  logic                                 rx_in_valid,
   input  logic [BYTE_W-1:0]                    rx_in_data,
   output logic                                 rx_in_ready,
   output logic                                 tx_out_valid,
   output logic [BYTE_W-1:0]                    tx_out_data,
   input  logic                                 tx_out_ready,
   output logic                                 irq_rx,
   output logic                                 irq_tx
);
   import mmsp_pkg::*;

   generate
      if (BYTE_W > BUS_W || BUS_W < 2) begin : g_bad_bus
         $error("mmsp_serial_port: byte must fit in the bus word");
      end
   endgenerate

   mmsp_reg_e            reg_sel;
   mmsp_acc_t            rx_acc;
   mmsp_acc_t            tx_acc;
   logic [LFSR_W-1:0]    rnd;
   logic                 rx_rdy, rx_ien, tx_rdy, tx_ien;
   logic [BYTE_W-1:0]    rx_byte;
   logic                 unused_ok;

   assign reg_sel   = mmsp_reg_e'(bus_addr[3:2]);
   assign unused_ok = ^{bus_addr[1:0], bus_wdata[BUS_W-1:BYTE_W]};

   always_comb begin
      rx_acc = '0;
      tx_acc = '0;
      rx_acc.ien_val = bus_wdata[CTL_IEN_BIT];
      tx_acc.ien_val = bus_wdata[CTL_IEN_BIT];
      if (bus_sel) begin
         case (reg_sel)
            SEL_RX_CTL: rx_acc.ctl_wr  = bus_we;
            SEL_RX_DAT: rx_acc.dat_acc = !bus_we;
            SEL_TX_CTL: tx_acc.ctl_wr  = bus_we;
            SEL_TX_DAT: tx_acc.dat_acc = bus_we;
            default: ;
         endcase
      end
   end

   mmsp_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED)) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .rnd   (rnd)
   );

   mmsp_rx_chan #(.BYTE_W(BYTE_W), .LFSR_W(LFSR_W), .GAP_MIN(GAP_MIN)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc      (rx_acc),
      .rnd      (rnd),
      .in_valid (rx_in_valid),
      .in_data  (rx_in_data),
      .in_ready (rx_in_ready),
      .rdy      (rx_rdy),
      .ien      (rx_ien),
      .byte_q   (rx_byte),
      .irq      (irq_rx)
   );

   mmsp_tx_chan #(.BYTE_W(BYTE_W), .LFSR_W(LFSR_W), .GAP_MIN(GAP_MIN)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc       (tx_acc),
      .wbyte     (bus_wdata[BYTE_W-1:0]),
      .rnd       (rnd),
      .out_valid (tx_out_valid),
      .out_data  (tx_out_data),
      .out_ready (tx_out_ready),
      .rdy       (tx_rdy),
      .ien       (tx_ien),
      .irq       (irq_tx)
   );

   always_comb begin
      bus_rdata = '0;
      case (reg_sel)
         SEL_RX_CTL: begin
            bus_rdata[CTL_RDY_BIT] = rx_rdy;
            bus_rdata[CTL_IEN_BIT] = rx_ien;
         end
         SEL_RX_DAT: bus_rdata[BYTE_W-1:0] = rx_byte;
         SEL_TX_CTL: begin
            bus_rdata[CTL_RDY_BIT] = tx_rdy;
            bus_rdata[CTL_IEN_BIT] = tx_ien;
         end
         default: ;
      endcase
   end

   a_r3_rx_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_rx && !rx_acc.dat_acc && !rx_acc.ctl_wr) |=> irq_rx);
   a_r3_tx_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_tx && !tx_acc.dat_acc && !tx_acc.ctl_wr) |=> irq_tx);
   a_r10_rx_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_acc.ctl_wr && !rx_acc.ien_val) |=> !irq_rx);
   a_r10_tx_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_acc.ctl_wr && !tx_acc.ien_val) |=> !irq_tx);
   a_r2_ctl_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == SEL_RX_CTL || reg_sel == SEL_TX_CTL) |-> (bus_rdata[BUS_W-1:2] == '0));
endmodule

// File: tb/mmsp_serial_port_bench.sv
module mmsp_serial_port_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rx_in_valid = 1'b0;
   logic [7:0]  rx_in_data = '0;
   logic        rx_in_ready;
   logic        tx_out_valid;
   logic [7:0]  tx_out_data;
   logic        tx_out_ready = 1'b0;
   logic        irq_rx, irq_tx;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   mmsp_serial_port u_mmsp_serial_port (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data), .rx_in_ready(rx_in_ready),
      .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data), .tx_out_ready(tx_out_ready),
      .irq_rx(irq_rx), .irq_tx(irq_tx));

   function automatic logic [31:0] ctl_word(input logic rdy, input logic en);
      return {30'd0, en, rdy};
   endfunction

   function automatic bit gap_ok(input int g);
      return (g >= 4) && (g <= 31);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #2 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] wd);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = wd;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic send(input logic [7:0] b);
      rx_in_valid = 1'b1; rx_in_data = b;
      while (!rx_in_ready) @(negedge clk);
      @(negedge clk);
      rx_in_valid = 1'b0;
   endtask

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [7:0]  b;
      int          g, gmin, gmax;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(4'h0, d); chk(d == ctl_word(0, 0), "R1", "rx ctl", d, ctl_word(0, 0));
      rd(4'h8, d); chk(d == ctl_word(1, 0), "R1", "tx ctl", d, ctl_word(1, 0));
      chk(!irq_rx && !irq_tx, "R1", "irqs", {irq_rx, irq_tx}, 0);
      chk(rx_in_ready && !tx_out_valid, "R1", "streams", {rx_in_ready, tx_out_valid}, 2);

      // R2 enable write and readback, tx data reads zero
      wr(4'h0, 32'hFFFF_FFFE);
      rd(4'h0, d); chk(d == ctl_word(0, 1), "R2", "rx ctl en", d, ctl_word(0, 1));
      rd(4'hC, d); chk(d == 0, "R2", "tx data read", d, 0);
      chk(!irq_rx, "R3", "no irq without byte", irq_rx, 0);

      // R4 accept, R3 irq
      send(8'hA5);
      rd(4'h0, d); chk(d == ctl_word(1, 1), "R4", "rx ready set", d, ctl_word(1, 1));
      chk(irq_rx && !rx_in_ready, "R3", "irq_rx with byte", {irq_rx, rx_in_ready}, 2);
      rx_in_valid = 1'b1; rx_in_data = 8'h3C;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chk(irq_rx && !rx_in_ready, "R3", "irq_rx held", {irq_rx, rx_in_ready}, 2);
      end
      rx_in_valid = 1'b0;
      rd(4'h4, d); chk(d == 32'hA5, "R4", "held byte not overwritten", d, 32'hA5);

      // R5 cleared, R6 idle load
      chk(!irq_rx && !rx_in_ready, "R5", "ready cleared", {irq_rx, rx_in_ready}, 0);
      rd(4'h4, d); chk(d == 32'hA5, "R6", "idle load old byte", d, 32'hA5);
      rd(4'h0, d); chk(d == ctl_word(0, 1), "R6", "idle load no change", d, ctl_word(0, 1));

      // R10 mask while ready
      send(8'h11);
      chk(irq_rx, "R3", "irq_rx again", irq_rx, 1);
      wr(4'h0, 32'h0);
      chk(!irq_rx, "R10", "irq_rx masked", irq_rx, 0);
      rd(4'h0, d); chk(d == ctl_word(1, 0), "R10", "ready kept", d, ctl_word(1, 0));
      wr(4'h0, 32'h2);
      chk(irq_rx, "R10", "irq_rx unmasked", irq_rx, 1);

      // R5 random receive stream with measured pauses
      gmin = 99; gmax = 0;
      rd(4'h4, d); chk(d == 32'h11, "R4", "byte 11", d, 32'h11);
      for (int n = 0; n < 30; n++) begin
         b = 8'($urandom);
         repeat ($urandom % 3) @(negedge clk);
         send(b);
         rd(4'h4, d); chk(d == {24'd0, b}, "R4", "random rx byte", d, b);
         g = 0;
         while (!rx_in_ready && g < 100) begin g++; @(negedge clk); end
         chk(gap_ok(g), "R5", "rx pause", g, 4);
         if (g < gmin) gmin = g;
         if (g > gmax) gmax = g;
      end
      chk(gmax > gmin, "R5", "rx pauses vary", gmax, gmin + 1);

      // R7 R8 R9 transmit with stalled sink
      wr(4'h8, 32'h2);
      chk(irq_tx, "R3", "irq_tx idle ready", irq_tx, 1);
      wr(4'hC, 32'hFFFF_FF5A);
      chk(tx_out_valid && tx_out_data == 8'h5A && !irq_tx, "R7", "tx presented",
          tx_out_data, 8'h5A);
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         chk(tx_out_valid && tx_out_data == 8'h5A, "R7", "tx held", tx_out_data, 8'h5A);
      end
      rd(4'h8, d); chk(d == ctl_word(0, 1), "R8", "ready waits for sink", d, ctl_word(0, 1));
      wr(4'hC, 32'h77);
      chk(tx_out_data == 8'h5A, "R9", "store ignored", tx_out_data, 8'h5A);
      tx_out_ready = 1'b1;
      @(negedge clk);
      tx_out_ready = 1'b0;
      chk(!tx_out_valid, "R7", "accepted", tx_out_valid, 0);
      rd(4'h8, d); chk(d == ctl_word(1, 1), "R8", "ready back", d, ctl_word(1, 1));
      chk(!tx_out_valid, "R9", "no resend", tx_out_valid, 0);

      // R8 pause with free sink
      tx_out_ready = 1'b1;
      gmin = 99; gmax = 0;
      for (int n = 0; n < 25; n++) begin
         b = 8'($urandom);
         wr(4'hC, {24'd0, b});
         chk(tx_out_valid && tx_out_data == b, "R7", "tx byte", tx_out_data, b);
         g = 0;
         d = 0;
         while (g < 100) begin
            rd(4'h8, d);
            if (d[0]) break;
            g++;
         end
         chk(gap_ok(g), "R8", "tx pause", g, 4);
         if (g < gmin) gmin = g;
         if (g > gmax) gmax = g;
      end
      chk(gmax > gmin, "R8", "tx pauses vary", gmax, gmin + 1);
      tx_out_ready = 1'b0;

      // R7 random sink stalls
      for (int n = 0; n < 25; n++) begin
         bit r;
         b = 8'($urandom);
         d = 0;
         while (!d[0]) rd(4'h8, d);
         wr(4'hC, {24'd0, b});
         do begin
            r = ($urandom % 3) == 0;
            tx_out_ready = r;
            chk(tx_out_valid && tx_out_data == b, "R7", "stalled byte", tx_out_data, b);
            @(negedge clk);
         end while (!r);
         tx_out_ready = 1'b0;
         chk(!tx_out_valid, "R7", "handshake done", tx_out_valid, 0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule